// File: doc/BRIEF.md
# Device Error Classification and Signaling Unit

This block sits in a PCI Express function next to the error detectors. Each detected error arrives as one event: a status vector naming the error, a flag that says whether the error is correctable, a flag that allows a non-fatal error to be treated as advisory, and the requester source ID. The block first removes every bit that is not supported for the event's class. It then picks one of four classes: correctable, advisory non-fatal, non-fatal or fatal. It updates the sticky device, correctable and uncorrectable status it owns, applies the masks and reporting enables supplied by the configuration space, and decides whether an error message goes upstream and with which severity.

For an uncorrectable error that is not masked, the block asks an external header-log store to record the header. That store answers in the same cycle with a full flag. When the store was full and the original message went out, the block injects a correctable header-log-overflow error on the next cycle. During that cycle it holds off new events.

Top module: `errsig_top`

## Requirements
- R1: The incoming status is ANDed with the supported mask of its class (correctable or uncorrectable). Unless exactly one bit remains, the event is dropped: no status bit changes, `hdr_req` stays low and no message is emitted.
- R2: An uncorrectable error is fatal when its bit is set in `cfg_unc_sev`, and non-fatal otherwise. A non-fatal error with `evt_maybe_adv` set is handled as a correctable advisory-non-fatal error (correctable bit 13).
- R3: A correctable error sets `dev_sta` bit 0 and its own `cor_sta` bit. When that bit is set in `cfg_cor_mask` no message is sent. Otherwise a correctable message is sent only while `cfg_cor_rep_en` is set.
- R4: If the advisory correctable bit is unmasked, an advisory error also sets its uncorrectable status bit. It raises `hdr_req` (with `hdr_vec` naming that bit) only when the bit is clear in `cfg_unc_mask`. A masked advisory bit changes only `dev_sta` and `cor_sta`.
- R5: An uncorrectable error sets `dev_sta` bit 2 if fatal or bit 1 if non-fatal, and always sets its `unc_sta` bit. When that bit is masked in `cfg_unc_mask`, there is no header request and no message. Otherwise `hdr_req` is raised.
- R6: An unmasked fatal error is reported when `cfg_serr_en` or `cfg_fat_rep_en` is set. An unmasked non-fatal error is reported when `cfg_serr_en` or `cfg_nf_rep_en` is set.
- R7: An unsupported-request error is uncorrectable bit 20. It also sets `dev_sta` bit 3. Its message is suppressed while `cfg_ur_rep_en` is clear. On the uncorrectable path, this suppression applies only while `cfg_serr_en` is also clear.
- R8: A message is a one-cycle `msg_valid` pulse in the cycle after the event is accepted. `msg_sev` is 0 for correctable, 1 for non-fatal and 2 for fatal, and `msg_src` is the event's source ID.
- R9: If `hdr_full` is high while `hdr_req` is high and the event's message is sent, then on the next cycle `evt_ready` is low and the block processes a correctable header-log-overflow error (correctable bit 15) with source ID 0.
- R10: After reset all status outputs are zero, `msg_valid` is low and `evt_ready` is high. Status bits only accumulate until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Event accepted this cycle when high |
| evt_status | input | 32 | Error status vector |
| evt_corr | input | 1 | Event is correctable |
| evt_maybe_adv | input | 1 | Non-fatal event may be advisory |
| evt_src | input | 16 | Source ID of the event |
| cfg_unc_sev | input | 32 | Uncorrectable severity (1 = fatal) |
| cfg_unc_mask | input | 32 | Uncorrectable mask |
| cfg_cor_mask | input | 32 | Correctable mask |
| cfg_serr_en | input | 1 | System-error enable |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Non-fatal reporting enable |
| cfg_fat_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| hdr_req | output | 1 | Header recording request |
| hdr_vec | output | 32 | Uncorrectable bit being recorded |
| hdr_full | input | 1 | Header store full (recording overflowed) |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_src | output | 16 | Message source ID |
| dev_sta | output | 4 | Device status: correctable, non-fatal, fatal, unsupported request |
| cor_sta | output | 32 | Correctable status |
| unc_sta | output | 32 | Uncorrectable status |

## Verification
The bench builds the block with its default parameters: 32-bit status vectors, 16-bit source IDs, and the standard supported-bit masks and bit positions. With these values, every one of the sixteen uncorrectable codes and eight correctable codes can be reached. Random bit picks often fall outside the supported masks or carry several bits, which exercises rejection. Fixing the advisory, unsupported-request and overflow positions at bits 13, 20 and 15 lets directed cases hit the advisory conversion, the unsupported-request gating with and without system-error enable, and the overflow follow-up. A bench function predicts each of these outcomes.

// File: rtl/errsig_pkg.sv
package errsig_pkg;

  localparam int STAT_W = 32;
  localparam int SRC_W  = 16;
  localparam int DSTA_W = 4;

  // device status bit positions
  localparam int DSTA_COR   = 0;
  localparam int DSTA_NF    = 1;
  localparam int DSTA_FATAL = 2;
  localparam int DSTA_UR    = 3;

  // default bit positions inside the status vectors
  localparam int ADV_POS_DEF = 13;
  localparam int HLO_POS_DEF = 15;
  localparam int UR_POS_DEF  = 20;

  localparam logic [STAT_W-1:0] UNC_SUP_DEF = 32'h03FF_F030;
  localparam logic [STAT_W-1:0] COR_SUP_DEF = 32'h0000_F1C1;
  localparam logic [STAT_W-1:0] UNC_SEV_DEF = 32'h0046_2030;

  typedef enum logic [1:0] {
    SEV_COR     = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL   = 2'd2
  } sev_e;

endpackage

// File: rtl/errsig_classify.sv
module errsig_classify
  import errsig_pkg::*;
#(
  parameter int                STAT_W_P = STAT_W,
  parameter logic [STAT_W_P-1:0] UNC_SUP = UNC_SUP_DEF,
  parameter logic [STAT_W_P-1:0] COR_SUP = COR_SUP_DEF,
  parameter int                ADV_POS  = ADV_POS_DEF,
  parameter int                UR_POS   = UR_POS_DEF
) (
  input  logic [STAT_W_P-1:0] status,
  input  logic                corr,
  input  logic                maybe_adv,
  input  logic [STAT_W_P-1:0] unc_sev,
  output logic                ok,
  output logic                path_cor,
  output logic                is_adv,
  output logic                is_fatal,
  output logic                is_ur,
  output logic [STAT_W_P-1:0] cor_bit,
  output logic [STAT_W_P-1:0] unc_bit
);

  localparam logic [STAT_W_P-1:0] ADV_VEC = STAT_W_P'(1) << ADV_POS;
  localparam logic [STAT_W_P-1:0] UR_VEC  = STAT_W_P'(1) << UR_POS;

  logic [STAT_W_P-1:0] filt;

  always_comb begin
    filt     = status & (corr ? COR_SUP : UNC_SUP);
    ok       = (filt != '0) && ((filt & (filt - STAT_W_P'(1))) == '0);
    is_fatal = !corr && ((filt & unc_sev) != '0);
    is_adv   = !corr && !is_fatal && maybe_adv;
    path_cor = corr || is_adv;
    is_ur    = !corr && (filt == UR_VEC);
    unc_bit  = corr ? '0 : filt;
    if (corr) begin
      cor_bit = filt;
    end else if (is_adv) begin
      cor_bit = ADV_VEC;
    end else begin
      cor_bit = '0;
    end
  end

endmodule

// File: rtl/errsig_decide.sv
module errsig_decide
  import errsig_pkg::*;
#(
  parameter int STAT_W_P = STAT_W
) (
  input  logic                fire,
  input  logic                ok,
  input  logic                path_cor,
  input  logic                is_adv,
  input  logic                is_fatal,
  input  logic                is_ur,
  input  logic [STAT_W_P-1:0] cor_bit,
  input  logic [STAT_W_P-1:0] unc_bit,
  input  logic [STAT_W_P-1:0] unc_mask,
  input  logic [STAT_W_P-1:0] cor_mask,
  input  logic                serr_en,
  input  logic                cor_en,
  input  logic                nf_en,
  input  logic                fat_en,
  input  logic                ur_en,
  output logic                rec_req,
  output logic                send,
  output logic [1:0]          sev,
  output logic [DSTA_W-1:0]   set_dsta,
  output logic [STAT_W_P-1:0] set_cor,
  output logic [STAT_W_P-1:0] set_unc
);

  logic act;
  logic cor_masked;
  logic unc_masked;

  always_comb begin
    act        = fire && ok;
    cor_masked = (cor_mask & cor_bit) != '0;
    unc_masked = (unc_mask & unc_bit) != '0;
    rec_req    = 1'b0;
    send       = 1'b0;
    sev        = SEV_COR;
    set_dsta   = '0;
    set_cor    = '0;
    set_unc    = '0;
    if (act) begin
      set_dsta[DSTA_UR] = is_ur;
      if (path_cor) begin
        set_dsta[DSTA_COR] = 1'b1;
        set_cor            = cor_bit;
        if (!cor_masked) begin
          if (is_adv) begin
            rec_req = !unc_masked;
            set_unc = unc_bit;
          end
          send = !(is_ur && !ur_en) && cor_en;
        end
      end else begin
        set_dsta[DSTA_FATAL] = is_fatal;
        set_dsta[DSTA_NF]    = !is_fatal;
        set_unc              = unc_bit;
        sev                  = is_fatal ? SEV_FATAL : SEV_NONFATAL;
        if (!unc_masked) begin
          rec_req = 1'b1;
          send    = !(is_ur && !ur_en && !serr_en) &&
                    (serr_en || (is_fatal ? fat_en : nf_en));
        end
      end
    end
  end

endmodule

// File: rtl/errsig_status.sv
module errsig_status
  import errsig_pkg::*;
#(
  parameter int STAT_W_P = STAT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DSTA_W-1:0]   set_dsta,
  input  logic [STAT_W_P-1:0] set_cor,
  input  logic [STAT_W_P-1:0] set_unc,
  output logic [DSTA_W-1:0]   dsta_q,
  output logic [STAT_W_P-1:0] cor_q,
  output logic [STAT_W_P-1:0] unc_q
);

  logic [DSTA_W-1:0]   dsta_d;
  logic [STAT_W_P-1:0] cor_d;
  logic [STAT_W_P-1:0] unc_d;
  logic                upd_en;

  always_comb begin
    upd_en = (set_dsta != '0) || (set_cor != '0) || (set_unc != '0);
    dsta_d = dsta_q | set_dsta;
    cor_d  = cor_q | set_cor;
    unc_d  = unc_q | set_unc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsta_q <= '0;
      cor_q  <= '0;
      unc_q  <= '0;
    end else if (upd_en) begin
      dsta_q <= dsta_d;
      cor_q  <= cor_d;
      unc_q  <= unc_d;
    end
  end

  // R10: status bits never fall while out of reset
  a_r10_unc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_q != '0) |=> ((unc_q & $past(unc_q)) == $past(unc_q)));
  a_r10_cor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_q != '0) |=> ((cor_q & $past(cor_q)) == $past(cor_q)));

endmodule

// File: rtl/errsig_top.sv
module errsig_top
  import errsig_pkg::*;
#(
  parameter int                  STAT_W_P = STAT_W,
  parameter int                  SRC_W_P  = SRC_W,
  parameter logic [STAT_W_P-1:0] UNC_SUP  = UNC_SUP_DEF,
  parameter logic [STAT_W_P-1:0] COR_SUP  = COR_SUP_DEF,
  parameter int                  ADV_POS  = ADV_POS_DEF,
  parameter int                  HLO_POS  = HLO_POS_DEF,
  parameter int                  UR_POS   = UR_POS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  output logic                evt_ready,
  input  logic [STAT_W_P-1:0] evt_status,
  input  logic                evt_corr,
  input  logic                evt_maybe_adv,
  input  logic [SRC_W_P-1:0]  evt_src,
  input  logic [STAT_W_P-1:0] cfg_unc_sev,
  input  logic [STAT_W_P-1:0] cfg_unc_mask,
  input  logic [STAT_W_P-1:0] cfg_cor_mask,
  input  logic                cfg_serr_en,
  input  logic                cfg_cor_rep_en,
  input  logic                cfg_nf_rep_en,
  input  logic                cfg_fat_rep_en,
  input  logic                cfg_ur_rep_en,
  output logic                hdr_req,
  output logic [STAT_W_P-1:0] hdr_vec,
  input  logic                hdr_full,
  output logic                msg_valid,
  output logic [1:0]          msg_sev,
  output logic [SRC_W_P-1:0]  msg_src,
  output logic [DSTA_W-1:0]   dev_sta,
  output logic [STAT_W_P-1:0] cor_sta,
  output logic [STAT_W_P-1:0] unc_sta
);

  localparam logic [STAT_W_P-1:0] HLO_VEC = STAT_W_P'(1) << HLO_POS;

  logic                ovf_pend_q, ovf_pend_d;
  logic                fire;
  logic [STAT_W_P-1:0] e_status;
  logic                e_corr, e_adv;
  logic [SRC_W_P-1:0]  e_src;

  logic                c_ok, c_path_cor, c_adv, c_fatal, c_ur;
  logic [STAT_W_P-1:0] c_cor_bit, c_unc_bit;

  logic                d_rec, d_send;
  logic [1:0]          d_sev;
  logic [DSTA_W-1:0]   d_set_dsta;
  logic [STAT_W_P-1:0] d_set_cor, d_set_unc;

  logic                msg_valid_d;
  logic [1:0]          msg_sev_d;
  logic [SRC_W_P-1:0]  msg_src_d;
  logic                msg_load;

  // event source select: a pending overflow error wins over the port
  always_comb begin
    evt_ready = !ovf_pend_q;
    fire      = ovf_pend_q || evt_valid;
    if (ovf_pend_q) begin
      e_status = HLO_VEC;
      e_corr   = 1'b1;
      e_adv    = 1'b0;
      e_src    = '0;
    end else begin
      e_status = evt_status;
      e_corr   = evt_corr;
      e_adv    = evt_maybe_adv;
      e_src    = evt_src;
    end
  end

  errsig_classify #(
    .STAT_W_P (STAT_W_P),
    .UNC_SUP  (UNC_SUP),
    .COR_SUP  (COR_SUP),
    .ADV_POS  (ADV_POS),
    .UR_POS   (UR_POS)
  ) i_classify (
    .status    (e_status),
    .corr      (e_corr),
    .maybe_adv (e_adv),
    .unc_sev   (cfg_unc_sev),
    .ok        (c_ok),
    .path_cor  (c_path_cor),
    .is_adv    (c_adv),
    .is_fatal  (c_fatal),
    .is_ur     (c_ur),
    .cor_bit   (c_cor_bit),
    .unc_bit   (c_unc_bit)
  );

  errsig_decide #(
    .STAT_W_P (STAT_W_P)
  ) i_decide (
    .fire     (fire),
    .ok       (c_ok),
    .path_cor (c_path_cor),
    .is_adv   (c_adv),
    .is_fatal (c_fatal),
    .is_ur    (c_ur),
    .cor_bit  (c_cor_bit),
    .unc_bit  (c_unc_bit),
    .unc_mask (cfg_unc_mask),
    .cor_mask (cfg_cor_mask),
    .serr_en  (cfg_serr_en),
    .cor_en   (cfg_cor_rep_en),
    .nf_en    (cfg_nf_rep_en),
    .fat_en   (cfg_fat_rep_en),
    .ur_en    (cfg_ur_rep_en),
    .rec_req  (d_rec),
    .send     (d_send),
    .sev      (d_sev),
    .set_dsta (d_set_dsta),
    .set_cor  (d_set_cor),
    .set_unc  (d_set_unc)
  );

  errsig_status #(
    .STAT_W_P (STAT_W_P)
  ) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_dsta (d_set_dsta),
    .set_cor  (d_set_cor),
    .set_unc  (d_set_unc),
    .dsta_q   (dev_sta),
    .cor_q    (cor_sta),
    .unc_q    (unc_sta)
  );

  always_comb begin
    hdr_req     = d_rec;
    hdr_vec     = d_rec ? c_unc_bit : '0;
    ovf_pend_d  = d_rec && hdr_full && d_send;
    msg_valid_d = d_send;
    msg_sev_d   = d_sev;
    msg_src_d   = e_src;
    msg_load    = d_send || msg_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pend_q <= 1'b0;
    end else begin
      ovf_pend_q <= ovf_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_sev   <= '0;
      msg_src   <= '0;
    end else if (msg_load) begin
      msg_valid <= msg_valid_d;
      msg_sev   <= msg_sev_d;
      msg_src   <= msg_src_d;
    end
  end

  // R8: only the three defined severity codes appear
  a_r8_sev_code: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'd3));
  // R9: the port is held off while the overflow error is injected
  a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_req && hdr_full && d_send) |=> !evt_ready);
  // R9: the injected error always lands in the overflow status bit
  a_r9_ovf_status: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> ((cor_sta & HLO_VEC) != '0));
  // R1: a rejected event leaves every status unchanged
  a_r1_reject_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !c_ok) |=>
      ($stable(unc_sta) && $stable(cor_sta) && $stable(dev_sta) && !msg_valid));
  // R5: header is requested only for uncorrectable bits
  a_r5_hdr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_req |-> $onehot0(hdr_vec) && (hdr_vec != '0));

endmodule

// File: tb/test_errsig_top.sv
module test_errsig_top;
  import errsig_pkg::*;

  localparam time CLK_P = 10ns;

  logic        clk, rst_n;
  logic        evt_valid, evt_ready;
  logic [31:0] evt_status;
  logic        evt_corr, evt_maybe_adv;
  logic [15:0] evt_src;
  logic [31:0] cfg_unc_sev, cfg_unc_mask, cfg_cor_mask;
  logic        cfg_serr_en, cfg_cor_rep_en, cfg_nf_rep_en, cfg_fat_rep_en, cfg_ur_rep_en;
  logic        hdr_req;
  logic [31:0] hdr_vec;
  logic        hdr_full;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic [3:0]  dev_sta;
  logic [31:0] cor_sta, unc_sta;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [3:0]  m_dsta;
  logic [31:0] m_cor, m_unc;

  errsig_top i_errsig_top (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_status(evt_status), .evt_corr(evt_corr), .evt_maybe_adv(evt_maybe_adv),
    .evt_src(evt_src), .cfg_unc_sev(cfg_unc_sev), .cfg_unc_mask(cfg_unc_mask),
    .cfg_cor_mask(cfg_cor_mask), .cfg_serr_en(cfg_serr_en),
    .cfg_cor_rep_en(cfg_cor_rep_en), .cfg_nf_rep_en(cfg_nf_rep_en),
    .cfg_fat_rep_en(cfg_fat_rep_en), .cfg_ur_rep_en(cfg_ur_rep_en),
    .hdr_req(hdr_req), .hdr_vec(hdr_vec), .hdr_full(hdr_full),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .dev_sta(dev_sta), .cor_sta(cor_sta), .unc_sta(unc_sta)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // expected behaviour from the requirements
  function automatic void model(
    input  logic [31:0] st, input logic c, input logic a,
    output logic rec, output logic snd, output logic [1:0] sv,
    output logic [3:0] sd, output logic [31:0] sc, output logic [31:0] su);
    logic [31:0] f;
    logic ok, fat, adv, ur;
    f   = st & (c ? UNC_SUP_DEF ^ UNC_SUP_DEF | COR_SUP_DEF : UNC_SUP_DEF);
    ok  = ($countones(f) == 1);
    rec = 0; snd = 0; sv = 2'd0; sd = '0; sc = '0; su = '0;
    if (!ok) return;
    fat = !c && ((f & cfg_unc_sev) != 0);
    adv = !c && !fat && a;
    ur  = !c && (f == 32'h0010_0000);
    sd[3] = ur;
    if (c || adv) begin
      logic [31:0] cb;
      cb = c ? f : 32'h0000_2000;
      sd[0] = 1; sc = cb;
      if ((cfg_cor_mask & cb) == 0) begin
        if (adv) begin
          rec = ((cfg_unc_mask & f) == 0);
          su  = f;
        end
        snd = !(ur && !cfg_ur_rep_en) && cfg_cor_rep_en;
      end
    end else begin
      sd[2] = fat; sd[1] = !fat; su = f;
      sv = fat ? 2'd2 : 2'd1;
      if ((cfg_unc_mask & f) == 0) begin
        rec = 1;
        snd = !(ur && !cfg_ur_rep_en && !cfg_serr_en) &&
              (cfg_serr_en || (fat ? cfg_fat_rep_en : cfg_nf_rep_en));
      end
    end
  endfunction

  task automatic check_state(input string rq);
    check({rq, " dev_sta"}, {28'd0, dev_sta}, {28'd0, m_dsta});
    check({rq, " cor_sta"}, cor_sta, m_cor);
    check({rq, " unc_sta"}, unc_sta, m_unc);
  endtask

  // caller is at a negedge
  task automatic run_evt(input string rq, input logic [31:0] st, input logic c,
                         input logic a, input logic [15:0] src, input logic full);
    logic rec, snd; logic [1:0] sv; logic [3:0] sd; logic [31:0] sc, su;
    logic pend;
    evt_status = st; evt_corr = c; evt_maybe_adv = a; evt_src = src;
    hdr_full = full; evt_valid = 1'b1;
    #1;
    model(st, c, a, rec, snd, sv, sd, sc, su);
    check({rq, " hdr_req"}, {31'd0, hdr_req}, {31'd0, rec});
    check({rq, " hdr_vec"}, hdr_vec, rec ? su : 32'd0);
    check({rq, " evt_ready"}, {31'd0, evt_ready}, 32'd1);
    pend = rec && full && snd;
    @(posedge clk); @(negedge clk);
    evt_valid = 1'b0;
    m_dsta |= sd; m_cor |= sc; m_unc |= su;
    check({rq, " msg_valid"}, {31'd0, msg_valid}, {31'd0, snd});
    if (snd) begin
      check({rq, " msg_sev"}, {30'd0, msg_sev}, {30'd0, sv});
      check({rq, " msg_src"}, {16'd0, msg_src}, {16'd0, src});
    end
    check_state(rq);
    if (pend) begin
      check("R9 ready low", {31'd0, evt_ready}, 32'd0);
      model(32'h0000_8000, 1'b1, 1'b0, rec, snd, sv, sd, sc, su);
      @(posedge clk); @(negedge clk);
      m_dsta |= sd; m_cor |= sc; m_unc |= su;
      check("R9 ovf msg_valid", {31'd0, msg_valid}, {31'd0, snd});
      if (snd) begin
        check("R9 ovf sev", {30'd0, msg_sev}, 32'd0);
        check("R9 ovf src", {16'd0, msg_src}, 32'd0);
      end
      check_state("R9 ovf");
      check("R9 ready back", {31'd0, evt_ready}, 32'd1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt_valid = 0; evt_status = 0; evt_corr = 0; evt_maybe_adv = 0; evt_src = 0;
    hdr_full = 0;
    m_dsta = 0; m_cor = 0; m_unc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_all(input logic s, input logic ce, input logic ne,
                         input logic fe, input logic ue);
    cfg_serr_en = s; cfg_cor_rep_en = ce; cfg_nf_rep_en = ne;
    cfg_fat_rep_en = fe; cfg_ur_rep_en = ue;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    cfg_unc_sev = UNC_SEV_DEF; cfg_unc_mask = 0; cfg_cor_mask = 0;
    cfg_all(0, 1, 1, 1, 1);
    do_reset();
    // R10 reset state
    check_state("R10 reset");
    check("R10 msg_valid", {31'd0, msg_valid}, 32'd0);
    check("R10 evt_ready", {31'd0, evt_ready}, 32'd1);

    // R1 rejects: two bits, unsupported bit, empty
    run_evt("R1 two bits", 32'h0000_3000, 1'b0, 1'b0, 16'h11, 1'b0);
    run_evt("R1 unsupported", 32'h0000_0002, 1'b1, 1'b0, 16'h12, 1'b0);
    run_evt("R1 empty", 32'h0, 1'b0, 1'b0, 16'h13, 1'b0);

    // R3 correctable sent, masked, disabled
    run_evt("R3 cor sent", 32'h0000_0040, 1'b1, 1'b0, 16'h21, 1'b0);
    cfg_cor_mask = 32'h0000_0080;
    run_evt("R3 cor masked", 32'h0000_0080, 1'b1, 1'b0, 16'h22, 1'b0);
    cfg_cor_mask = 0; cfg_all(0, 0, 1, 1, 1);
    run_evt("R3 cor disabled", 32'h0000_0001, 1'b1, 1'b0, 16'h23, 1'b0);

    // R2 / R6 severity from register, fatal and nonfatal enables
    do_reset();
    cfg_all(0, 1, 1, 0, 1);
    run_evt("R6 fatal blocked", 32'h0004_0000, 1'b0, 1'b0, 16'h31, 1'b0);
    cfg_all(1, 1, 0, 0, 1);
    run_evt("R6 fatal via serr", 32'h0000_0010, 1'b0, 1'b0, 16'h32, 1'b0);
    cfg_all(0, 1, 1, 1, 1);
    run_evt("R2 nonfatal", 32'h0000_1000, 1'b0, 1'b0, 16'h33, 1'b0);
    cfg_unc_sev = UNC_SEV_DEF | 32'h0000_1000;
    run_evt("R2 sev reg fatal", 32'h0000_1000, 1'b0, 1'b1, 16'h34, 1'b0);
    cfg_unc_sev = UNC_SEV_DEF;

    // R4 advisory: unmasked, unc-masked, cor-masked
    do_reset();
    run_evt("R4 advisory", 32'h0000_4000, 1'b0, 1'b1, 16'h41, 1'b0);
    cfg_unc_mask = 32'h0000_8000;
    run_evt("R4 adv unc masked", 32'h0000_8000, 1'b0, 1'b1, 16'h42, 1'b0);
    do_reset();
    cfg_unc_mask = 0; cfg_cor_mask = 32'h0000_2000;
    run_evt("R4 adv cor masked", 32'h0001_0000, 1'b0, 1'b1, 16'h43, 1'b0);
    cfg_cor_mask = 0;

    // R5 masked uncorrectable
    cfg_unc_mask = 32'h0020_0000;
    run_evt("R5 unc masked", 32'h0020_0000, 1'b0, 1'b0, 16'h51, 1'b0);
    cfg_unc_mask = 0;

    // R7 unsupported request gating
    do_reset();
    cfg_all(0, 1, 1, 1, 0);
    run_evt("R7 ur suppressed", 32'h0010_0000, 1'b0, 1'b0, 16'h71, 1'b0);
    cfg_all(1, 1, 1, 1, 0);
    run_evt("R7 ur via serr", 32'h0010_0000, 1'b0, 1'b0, 16'h72, 1'b0);
    cfg_all(1, 1, 1, 1, 0);
    run_evt("R7 ur adv suppressed", 32'h0010_0000, 1'b0, 1'b1, 16'h73, 1'b0);

    // R9 overflow follow-up, and none when the message is not sent
    do_reset();
    cfg_all(0, 1, 1, 1, 1);
    run_evt("R9 overflow", 32'h0000_0020, 1'b0, 1'b0, 16'h91, 1'b1);
    cfg_all(0, 1, 0, 1, 1);
    run_evt("R9 no msg no ovf", 32'h0000_4000, 1'b0, 1'b0, 16'h92, 1'b1);
    check("R9 ready after silent", {31'd0, evt_ready}, 32'd1);

    // R8 plus everything: constrained random
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] st;
      if (i % 50 == 0) do_reset();
      st = ($urandom % 8 == 0) ? $urandom : (32'd1 << ($urandom % 26));
      cfg_unc_mask = $urandom & $urandom & $urandom;
      cfg_cor_mask = $urandom & $urandom & $urandom;
      cfg_unc_sev  = ($urandom % 2) ? UNC_SEV_DEF : $urandom;
      cfg_all($urandom % 2, $urandom % 4 != 0, $urandom % 4 != 0,
              $urandom % 4 != 0, $urandom % 2);
      run_evt("R8 random", st, $urandom % 2, $urandom % 2, 16'($urandom),
              $urandom % 3 == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule